// File: doc/BRIEF.md
# Addressable Bit Latch with Demultiplex Mode

An eight-bit storage register written one bit at a time. A three-bit select picks one bit position, and a single serial data bit is written into that position. Two control inputs choose the mode. The first is a write inhibit and the second is a functional clear. Together they select one of four modes: addressed write, hold, clear of every bit, and an active-high one-of-eight demultiplexer. In demultiplexer mode the selected output follows the data and every other output is held at zero. All eight stored bits can be read in parallel at all times.

The model is clocked and synchronous. The controls, select and data are sampled on the rising edge of the system clock, and the stored bits are registered outputs. A separate active-low power-on reset clears the store and overrides every other input. The storage width is a parameter, and the select width is derived from it.

Top module: `addr_bit_latch`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every bit of `q` is 0 after that edge, whatever the other inputs are.
- R2: With `wr_inhibit`=0 and `clear_req`=0 (write mode), the bit selected by `sel` takes the value of `din` at the edge, and every other bit keeps its value.
- R3: `sel` is unsigned binary with `sel[0]` as the least significant bit. The value n selects bit `q[n]`.
- R4: With `wr_inhibit`=1 and `clear_req`=0 (hold mode), no bit of `q` changes, whatever `sel` and `din` are.
- R5: With `wr_inhibit`=1 and `clear_req`=1 (clear mode), every bit of `q` is 0 after the edge. Clear mode takes priority over every other functional mode.
- R6: With `wr_inhibit`=0 and `clear_req`=1 (demultiplex mode), after the edge `q[sel]` equals `din` and every other bit is 0.
- R7: A move from demultiplex mode into hold mode keeps the pattern from the last demultiplex edge: the selected bit keeps its data value and the others stay 0.
- R8: The value stored in a bit is the `din` sampled at the last write edge before `wr_inhibit` goes high. Later changes of `din` have no effect.
- R9: `q` changes only at a rising clock edge, one edge after its inputs are sampled. It is readable in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| wr_inhibit | input | 1 | 1 blocks addressed writes; with `clear_req`, picks the mode |
| clear_req | input | 1 | Functional clear; with `wr_inhibit`, picks the mode |
| sel | input | 3 | Binary bit select, LSB first |
| din | input | 1 | Serial data bit |
| q | output | 8 | Parallel stored bits |

## Verification
The hardest case to reach from the ports is the move out of demultiplex mode. The block must then freeze the one-hot pattern it was driving, and not fall back to the contents it held before demultiplexing. To reach it, the bench first fills the store with a mixed pattern through addressed writes. It then runs demultiplex steps at several selects with both data values, and enters hold with the select and data changed in the same cycle. A stale pattern or a wrong priority therefore shows up at the outputs. A second hard case is data that changes in the cycle when the inhibit rises. The bench drives the new data together with the inhibit to confirm that the value from the earlier edge is the one kept.

// File: rtl/abl_pkg.sv
// Shared types for the addressable bit latch.
package abl_pkg;
    // Functional mode, decoded from the inhibit and clear controls.
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_WRITE = 2'd1,
        MODE_DEMUX = 2'd2,
        MODE_CLEAR = 2'd3
    } abl_mode_e;
endpackage

// File: rtl/abl_mode_dec.sv
// Mode decoder: turns write-inhibit and clear-request into one mode.
// Priority: clear, then demultiplex, then write, then hold.
// Assumes both inputs are already synchronous to the block clock.
module abl_mode_dec
    import abl_pkg::*;
(
    input  logic      wr_inhibit,
    input  logic      clear_req,
    output abl_mode_e mode
);
    // Priority decode of the two control inputs.
    always_comb begin
        if (clear_req && wr_inhibit)  mode = MODE_CLEAR;
        else if (clear_req)           mode = MODE_DEMUX;
        else if (!wr_inhibit)         mode = MODE_WRITE;
        else                          mode = MODE_HOLD;
    end
endmodule

// File: rtl/abl_sel_dec.sv
// Binary-to-one-hot select decoder. Bit n of hit is set when sel == n.
// Assumes WIDTH <= 2**SEL_W.
module abl_sel_dec #(
    parameter int WIDTH = 8,
    parameter int SEL_W = $clog2(WIDTH)
) (
    input  logic [SEL_W-1:0] sel,
    output logic [WIDTH-1:0] hit
);
    // One comparator per bit position.
    for (genvar i = 0; i < WIDTH; i++) begin : g_hit
        assign hit[i] = (sel == SEL_W'(i));
    end
endmodule

// File: rtl/abl_bit_cell.sv
// One storage bit. It updates on the clock edge according to the mode
// and to whether this bit is the selected one.
// Assumes a synchronous active-low power-on reset.
module abl_bit_cell
    import abl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  abl_mode_e mode,
    input  logic      hit,
    input  logic      din,
    output logic      q
);
    // Per-bit next-state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            case (mode)
                MODE_CLEAR: q <= 1'b0;
                MODE_DEMUX: q <= hit & din;
                MODE_WRITE: if (hit) q <= din;
                default:    q <= q;
            endcase
        end
    end
endmodule

// File: rtl/addr_bit_latch.sv
// Addressable bit latch, top level. It decodes the mode and the select,
// then drives WIDTH bit cells. Outputs are the registered bits.
// Assumes all inputs are synchronous to clk.
module addr_bit_latch
    import abl_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int SEL_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_inhibit,
    input  logic             clear_req,
    input  logic [SEL_W-1:0] sel,
    input  logic             din,
    output logic [WIDTH-1:0] q
);
    abl_mode_e        mode;
    logic [WIDTH-1:0] hit;

    abl_mode_dec u_mode (
        .wr_inhibit (wr_inhibit),
        .clear_req  (clear_req),
        .mode       (mode)
    );

    abl_sel_dec #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_sel (
        .sel (sel),
        .hit (hit)
    );

    // Storage array, one cell per bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        abl_bit_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (mode),
            .hit   (hit[i]),
            .din   (din),
            .q     (q[i])
        );
    end

    // R1
    por_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (q == '0));

    // R3
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(hit));

    // R2
    write_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_inhibit && !clear_req) |=> (q[$past(sel)] == $past(din)));

    // R2
    write_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_inhibit && !clear_req) |=>
        ((q & ~(WIDTH'(1) << $past(sel))) == ($past(q) & ~(WIDTH'(1) << $past(sel)))));

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_inhibit && !clear_req) |=> $stable(q));

    // R5
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_inhibit && clear_req) |=> (q == '0));

    // R6
    demux_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_inhibit && clear_req) |=>
        (q == ((WIDTH'(1) << $past(sel)) & {WIDTH{$past(din)}})));

    // R6
    demux_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_inhibit && clear_req) |=> $onehot0(q));
endmodule

// File: tb/sim_addr_bit_latch.sv
// Directed bench for addr_bit_latch: one task per scenario.
module sim_addr_bit_latch;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_inhibit;
    logic       clear_req;
    logic [2:0] sel;
    logic       din;
    logic [7:0] q;
    logic [7:0] exp_q;
    int         n_chk = 0;
    int         n_fail = 0;

    addr_bit_latch u0 (
        .clk(clk), .rst_n(rst_n), .wr_inhibit(wr_inhibit),
        .clear_req(clear_req), .sel(sel), .din(din), .q(q)
    );

    // 250 MHz clock: 4 time units per period
    always #2 clk = ~clk;

    // Compare q with the expected value and count the result.
    task automatic chk(input string req, input logic [7:0] want);
        n_chk++;
        if (q !== want) begin
            n_fail++;
            $display("FAIL %s: q=%h expected %h", req, q, want);
        end
    endtask

    // From a negedge: drive the inputs, pass one rising edge, return at the negedge.
    task automatic step(input logic inh, input logic clr, input logic [2:0] s, input logic d);
        wr_inhibit = inh; clear_req = clr; sel = s; din = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Power-on reset with a write request pending. R1
    task automatic t_reset();
        rst_n = 1'b0;
        step(1'b0, 1'b0, 3'd3, 1'b1);
        step(1'b0, 1'b0, 3'd5, 1'b1);
        exp_q = 8'h00;
        chk("R1 reset", exp_q);
        rst_n = 1'b1;
    endtask

    // Addressed writes to every position, then clear one bit. R2 R3
    task automatic t_write();
        for (int n = 0; n < 8; n++) begin
            step(1'b0, 1'b0, 3'(n), n[0]);
            exp_q[n] = n[0];
            chk("R2 write", exp_q);
        end
        step(1'b0, 1'b0, 3'b110, 1'b1);
        exp_q[6] = 1'b1;
        chk("R3 select 6 binary", exp_q);
        step(1'b0, 1'b0, 3'b011, 1'b0);
        exp_q[3] = 1'b0;
        chk("R3 select 3 binary", exp_q);
    endtask

    // Hold with the select and data moving. R4
    task automatic t_hold();
        for (int n = 0; n < 8; n++) begin
            step(1'b1, 1'b0, 3'(n), ~exp_q[n]);
        end
        chk("R4 hold", exp_q);
    endtask

    // Timing of an update and capture of data at the inhibit edge. R8 R9
    task automatic t_capture();
        wr_inhibit = 1'b0; clear_req = 1'b0; sel = 3'd1; din = ~exp_q[1];
        #1;
        chk("R9 no change before edge", exp_q);
        @(posedge clk);
        @(negedge clk);
        exp_q[1] = ~exp_q[1];
        chk("R9 change after edge", exp_q);
        step(1'b1, 1'b0, 3'd1, ~exp_q[1]);
        step(1'b1, 1'b0, 3'd1, exp_q[1]);
        step(1'b1, 1'b0, 3'd1, ~exp_q[1]);
        chk("R8 captured value kept", exp_q);
    endtask

    // Demultiplexer mode, then hold. R6 R7
    task automatic t_demux();
        step(1'b0, 1'b1, 3'd5, 1'b1);
        exp_q = 8'h20;
        chk("R6 demux sel5 d1", exp_q);
        step(1'b0, 1'b1, 3'd2, 1'b0);
        exp_q = 8'h00;
        chk("R6 demux sel2 d0", exp_q);
        step(1'b0, 1'b1, 3'd7, 1'b1);
        exp_q = 8'h80;
        chk("R6 demux sel7 d1", exp_q);
        step(1'b1, 1'b0, 3'd0, 1'b0);
        chk("R7 hold after demux", exp_q);
        step(1'b1, 1'b0, 3'd4, 1'b1);
        chk("R7 hold after demux 2", exp_q);
    endtask

    // Clear mode, and its priority. R5
    task automatic t_clear();
        step(1'b0, 1'b0, 3'd0, 1'b1);
        step(1'b0, 1'b0, 3'd2, 1'b1);
        exp_q = 8'h85;
        chk("R2 refill", exp_q);
        step(1'b1, 1'b1, 3'd0, 1'b1);
        exp_q = 8'h00;
        chk("R5 clear all", exp_q);
    endtask

    // Power-on reset during operation, with clear and demux requests. R1
    task automatic t_reset_mid();
        step(1'b0, 1'b0, 3'd4, 1'b1);
        exp_q = 8'h10;
        chk("R2 before reset", exp_q);
        rst_n = 1'b0;
        step(1'b0, 1'b1, 3'd6, 1'b1);
        exp_q = 8'h00;
        chk("R1 reset over demux", exp_q);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 3'd6, 1'b1);
        chk("R4 hold after reset", exp_q);
    endtask

    // Print the summary line and end the run.
    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Main sequence.
    initial begin
        rst_n = 1'b0; wr_inhibit = 1'b1; clear_req = 1'b0; sel = '0; din = 1'b0;
        exp_q = '0;
        @(negedge clk);
        t_reset();
        t_write();
        t_hold();
        t_capture();
        t_demux();
        t_clear();
        t_reset_mid();
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end
endmodule